// File: doc/BRIEF.md
# Message Record/Playback Trigger Controller

This block is the control state machine of a voice message store that is addressed by slots. A four-bit start slot and a four-bit end slot pick an inclusive span of a row-organised store. Each slot holds a fixed number of rows, and each row lasts a fixed number of sample ticks. Three active-low triggers start operations: record, toggle play and hold play. They arrive already debounced and synchronised. The block sequences the row address over the span and drives these outputs: a record enable, a play enable, a one-cycle end-of-message (EOM) write strobe, an active-low LED, a feed-through enable and a one-cycle power-down request.

The record trigger decides its own mode from how long it is held low. A hold of at least `HOLD_TICKS` ticks gives level-hold recording, which stops on release. A shorter pulse gives toggle recording, which stops on the next press. Playback ends early at a row whose EOM flag is set. The block keeps one EOM flag per row: recording clears the flag of each row it passes and sets the flag of the row where it stops. A play trigger always overrides a recording in progress. Hold play loops over the span for as long as its input stays low.

Top module: `msg_op_ctrl`

## Requirements
- R1: A falling record input in idle, with end slot >= start slot, starts recording at row 8*start on the next cycle; rec_en_o is high and led_no is low for the whole recording.
- R2: If the record input stays low for HOLD_TICKS ticks after its press, recording is level-hold and stops when the input returns high.
- R3: If the record input returns high before HOLD_TICKS ticks, recording continues in toggle mode and stops on the next falling edge of the record input.
- R4: Recording stops at the end of the last row of the end slot (row 8*end+7); the EOM strobe is issued with row_o equal to that row.
- R5: Every stop of recording that is not a play override issues one eom_wr_o strobe with row_o equal to the current row and one pwr_dn_o in the same cycle; LED and rec_en_o are released on the next cycle.
- R6: Toggle play runs from row 8*start and ends at the end of the first row whose EOM flag is set, or at the end of row 8*end+7. It then issues pwr_dn_o. An LED low pulse follows only when an EOM flag ended the play.
- R7: A second falling edge of the toggle-play input during toggle play stops it with pwr_dn_o and no LED pulse.
- R8: Hold play stops with pwr_dn_o when its input rises. When a pass reaches an EOM row or the last row, play restarts at the start row with no pwr_dn_o, and an LED pulse is given for each EOM.
- R9: A falling play input during recording issues an EOM strobe at the current row with no power-down. Play of the latched span then begins on the next cycle in the matching play mode, and pwr_dn_o is issued when that play ends. If the play trigger falls in the same cycle that recording reaches the end row, the play takes priority.
- R10: ft_en_o follows the inverted feed-through input one cycle later while idle. It keeps its value during recording, is low during any play, and is restored when play ends.
- R11: While an operation is active, the slot inputs, the feed-through input and the trigger inputs that do not belong to the active operation have no effect on the span, the row sequence or the outputs.
- R12: A trigger with end slot < start slot is rejected: the block stays idle and issues no strobe.
- R13: Each LED end-of-message pulse holds led_no low for exactly LED_TICKS sample ticks.
- R14: After reset the block is idle: rec_en_o, play_en_o, ft_en_o, eom_wr_o and pwr_dn_o are low, led_no is high and row_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sample tick that paces the row timing |
| start_slot_i | input | SLOT_W | First slot of the span |
| end_slot_i | input | SLOT_W | Last slot of the span (inclusive) |
| rec_ni | input | 1 | Record trigger, active low |
| play_edge_ni | input | 1 | Toggle play trigger, active low |
| play_lvl_ni | input | 1 | Hold play input, active low |
| ft_ni | input | 1 | Feed-through request, active low |
| rec_en_o | output | 1 | Recording active |
| play_en_o | output | 1 | Playback active |
| eom_wr_o | output | 1 | EOM marker write strobe for row_o |
| row_o | output | SLOT_W+SLOT_ROW_W | Current store row |
| led_no | output | 1 | LED drive, active low |
| ft_en_o | output | 1 | Feed-through path enable |
| pwr_dn_o | output | 1 | Power-down request strobe |

## Verification
The case that matters most is a cycle in which two functions meet: recording reaches the end of its last row, and a play trigger falls in that same cycle. The bench produces this case by counting cycles from the record press. It drives the toggle-play input low in exactly the cycle of the final row tick. The scoreboard then requires the strobes in this order: one EOM strobe at the end row, with no power-down beside it; a full play of the new span; and only after that play, the power-down and the LED pulse. A design that lets the end-of-span stop win would emit the power-down too early, and the scoreboard would see the events out of order.

// File: rtl/msg_op_pkg.sv
package msg_op_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REC_PEND,
    ST_REC_EDGE,
    ST_REC_LVL,
    ST_PLAY_EDGE,
    ST_PLAY_LVL
  } op_state_e;
endpackage

// File: rtl/row_walker.sv
module row_walker #(
  parameter int ROW_W     = 7,
  parameter int ROW_TICKS = 1000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             load_i,
  input  logic [ROW_W-1:0] load_row_i,
  input  logic [ROW_W-1:0] end_row_i,
  output logic [ROW_W-1:0] row_o,
  output logic             wrap_o,
  output logic             at_end_o
);
  localparam int CNT_W = (ROW_TICKS > 1) ? $clog2(ROW_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ROW_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [ROW_W-1:0] row_q;

  assign at_end_o = (row_q == end_row_i);
  assign wrap_o   = run_i & tick_i & (cnt_q == LAST);
  assign row_o    = row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      row_q <= '0;
    end else if (load_i) begin
      cnt_q <= '0;
      row_q <= load_row_i;
    end else if (run_i && tick_i) begin
      if (cnt_q == LAST) begin
        cnt_q <= '0;
        if (!at_end_o) row_q <= row_q + 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R4: a running walk never passes the latched end row
  a_r4_row_in_span: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i)) |-> (row_q <= end_row_i));
endmodule

// File: rtl/hold_timer.sv
module hold_timer #(
  parameter int HOLD_TICKS = 8000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic cnt_en_i,
  output logic done_o
);
  localparam int HT_W = $clog2(HOLD_TICKS + 1);
  localparam logic [HT_W-1:0] LIMIT = HT_W'(HOLD_TICKS);

  logic [HT_W-1:0] cnt_q;

  assign done_o = (cnt_q == LIMIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i)              cnt_q <= '0;
    else if (cnt_en_i && !done_o) cnt_q <= cnt_q + 1'b1;
  end

  a_r2_hold_capped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIMIT);
endmodule

// File: rtl/eom_flags.sv
module eom_flags #(
  parameter int ROW_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [ROW_W-1:0] addr_i,
  output logic             flag_o
);
  localparam int ROWS = 1 << ROW_W;

  logic [ROWS-1:0] flags_q;

  assign flag_o = flags_q[addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flags_q <= '0;
    else if (set_i)  flags_q[addr_i] <= 1'b1;
    else if (clr_i)  flags_q[addr_i] <= 1'b0;
  end

  a_r5_marker_stored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flags_q[$past(addr_i)]);
endmodule

// File: rtl/led_stretch.sv
module led_stretch #(
  parameter int LED_TICKS = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic start_i,
  output logic active_o
);
  localparam int LW = $clog2(LED_TICKS + 1);

  logic [LW-1:0] cnt_q;

  assign active_o = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (start_i)            cnt_q <= LW'(LED_TICKS);
    else if (tick_i && active_o) cnt_q <= cnt_q - 1'b1;
  end

  a_r13_pulse_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> active_o);
  a_r13_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !start_i && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/msg_op_ctrl.sv
module msg_op_ctrl
  import msg_op_pkg::*;
#(
  parameter int SLOT_W     = 4,
  parameter int SLOT_ROW_W = 3,
  parameter int ROW_TICKS  = 1000,
  parameter int HOLD_TICKS = 8000,
  parameter int LED_TICKS  = 2000
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         tick_i,
  input  logic [SLOT_W-1:0]            start_slot_i,
  input  logic [SLOT_W-1:0]            end_slot_i,
  input  logic                         rec_ni,
  input  logic                         play_edge_ni,
  input  logic                         play_lvl_ni,
  input  logic                         ft_ni,
  output logic                         rec_en_o,
  output logic                         play_en_o,
  output logic                         eom_wr_o,
  output logic [SLOT_W+SLOT_ROW_W-1:0] row_o,
  output logic                         led_no,
  output logic                         ft_en_o,
  output logic                         pwr_dn_o
);
  localparam int ROW_W = SLOT_W + SLOT_ROW_W;

  op_state_e        state_q, state_d;
  logic             rec_q, pe_q, pl_q, ft_q;
  logic [ROW_W-1:0] start_row_q, end_row_q, in_start_row, in_end_row, load_row, row;
  logic             rec_fall, rec_rise, pe_fall, pl_fall, pl_rise, any_trig;
  logic             rec_act, play_act, load, latch, eom_set, pd, led_start;
  logic             wrap, at_end, flag, hold_done, led_act;

  assign rec_fall = rec_q & ~rec_ni;
  assign rec_rise = ~rec_q & rec_ni;
  assign pe_fall  = pe_q & ~play_edge_ni;
  assign pl_fall  = pl_q & ~play_lvl_ni;
  assign pl_rise  = ~pl_q & play_lvl_ni;
  assign any_trig = rec_fall | pe_fall | pl_fall;

  assign in_start_row = {start_slot_i, {SLOT_ROW_W{1'b0}}};
  assign in_end_row   = {end_slot_i, {SLOT_ROW_W{1'b1}}};

  assign rec_act  = (state_q == ST_REC_PEND) || (state_q == ST_REC_EDGE) || (state_q == ST_REC_LVL);
  assign play_act = (state_q == ST_PLAY_EDGE) || (state_q == ST_PLAY_LVL);

  always_comb begin
    state_d   = state_q;
    load      = 1'b0;
    load_row  = start_row_q;
    latch     = 1'b0;
    eom_set   = 1'b0;
    pd        = 1'b0;
    led_start = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (any_trig && (end_slot_i >= start_slot_i)) begin
          latch    = 1'b1;
          load     = 1'b1;
          load_row = in_start_row;
          if (pe_fall)      state_d = ST_PLAY_EDGE;
          else if (pl_fall) state_d = ST_PLAY_LVL;
          else              state_d = ST_REC_PEND;
        end
      end
      ST_REC_PEND, ST_REC_EDGE, ST_REC_LVL: begin
        if (pe_fall || pl_fall) begin
          // play wins over any stop condition in the same cycle
          eom_set = 1'b1;
          load    = 1'b1;
          state_d = pe_fall ? ST_PLAY_EDGE : ST_PLAY_LVL;
        end else if ((wrap && at_end) ||
                     (state_q == ST_REC_EDGE && rec_fall) ||
                     (state_q == ST_REC_LVL && rec_rise)) begin
          eom_set = 1'b1;
          pd      = 1'b1;
          state_d = ST_IDLE;
        end else if (state_q == ST_REC_PEND) begin
          if (rec_rise)       state_d = ST_REC_EDGE;
          else if (hold_done) state_d = ST_REC_LVL;
        end
      end
      ST_PLAY_EDGE: begin
        if (pe_fall) begin
          pd      = 1'b1;
          state_d = ST_IDLE;
        end else if (wrap && (flag || at_end)) begin
          pd        = 1'b1;
          led_start = flag;
          state_d   = ST_IDLE;
        end
      end
      ST_PLAY_LVL: begin
        if (pl_rise) begin
          pd      = 1'b1;
          state_d = ST_IDLE;
        end else if (wrap && (flag || at_end)) begin
          led_start = flag;
          load      = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      rec_q       <= 1'b1;
      pe_q        <= 1'b1;
      pl_q        <= 1'b1;
      ft_q        <= 1'b0;
      start_row_q <= '0;
      end_row_q   <= '0;
    end else begin
      state_q <= state_d;
      rec_q   <= rec_ni;
      pe_q    <= play_edge_ni;
      pl_q    <= play_lvl_ni;
      if (state_q == ST_IDLE) ft_q <= ~ft_ni;
      if (latch) begin
        start_row_q <= in_start_row;
        end_row_q   <= in_end_row;
      end
    end
  end

  row_walker #(.ROW_W(ROW_W), .ROW_TICKS(ROW_TICKS)) i_walker (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .run_i     (rec_act | play_act),
    .load_i    (load),
    .load_row_i(load_row),
    .end_row_i (end_row_q),
    .row_o     (row),
    .wrap_o    (wrap),
    .at_end_o  (at_end)
  );

  hold_timer #(.HOLD_TICKS(HOLD_TICKS)) i_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (state_q != ST_REC_PEND),
    .cnt_en_i(tick_i & ~rec_ni),
    .done_o  (hold_done)
  );

  eom_flags #(.ROW_W(ROW_W)) i_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (eom_set),
    .clr_i (rec_act),
    .addr_i(row),
    .flag_o(flag)
  );

  led_stretch #(.LED_TICKS(LED_TICKS)) i_led (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .start_i (led_start),
    .active_o(led_act)
  );

  assign rec_en_o  = rec_act;
  assign play_en_o = play_act;
  assign eom_wr_o  = eom_set;
  assign pwr_dn_o  = pd;
  assign row_o     = row;
  assign led_no    = ~(rec_act | led_act);
  assign ft_en_o   = ft_q & ~play_act;

  a_r5_pd_ends_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_dn_o |=> (!rec_en_o && !play_en_o));
  a_r9_override_plays: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_en_o && (pe_fall || pl_fall)) |=> play_en_o);
  a_r9_override_no_pd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_en_o && (pe_fall || pl_fall)) |-> (eom_wr_o && !pwr_dn_o));
  a_r6_no_marker_in_play: assert property (@(posedge clk_i) disable iff (!rst_ni)
    play_en_o |-> !eom_wr_o);
  a_r12_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rec_en_o && !play_en_o && any_trig && (end_slot_i < start_slot_i)) |=>
      (!rec_en_o && !play_en_o));
  a_r11_span_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rec_en_o || play_en_o) && $past(rec_en_o || play_en_o)) |-> $stable(end_row_q));
endmodule

// File: tb/test_msg_op_ctrl.sv
`timescale 1ns/1ps
module test_msg_op_ctrl;
  localparam int ROW_T  = 3;
  localparam int HOLD_T = 40;
  localparam int LED_T  = 4;
  localparam int EV_EOM = 0;
  localparam int EV_PD  = 1;
  localparam int EV_LED = 2;

  typedef struct {
    int    kind;
    int    row;
    string req;
  } ev_t;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b1;
  logic [3:0] start_slot_i = '0;
  logic [3:0] end_slot_i = '0;
  logic       rec_ni = 1'b1, play_edge_ni = 1'b1, play_lvl_ni = 1'b1, ft_ni = 1'b1;
  logic       rec_en_o, play_en_o, eom_wr_o, led_no, ft_en_o, pwr_dn_o;
  logic [6:0] row_o;

  int   checks = 0;
  int   errors = 0;
  int   cyc = 0;
  int   led_run = 0;
  bit   done = 1'b0;
  ev_t  exp_q[$];

  always #2 clk_i = ~clk_i;

  msg_op_ctrl #(.ROW_TICKS(ROW_T), .HOLD_TICKS(HOLD_T), .LED_TICKS(LED_T)) i_msg_op_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .start_slot_i(start_slot_i), .end_slot_i(end_slot_i),
    .rec_ni(rec_ni), .play_edge_ni(play_edge_ni), .play_lvl_ni(play_lvl_ni), .ft_ni(ft_ni),
    .rec_en_o(rec_en_o), .play_en_o(play_en_o), .eom_wr_o(eom_wr_o), .row_o(row_o),
    .led_no(led_no), .ft_en_o(ft_en_o), .pwr_dn_o(pwr_dn_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic expect_ev(input int kind, input int row, input string req);
    ev_t e;
    e.kind = kind; e.row = row; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic got_ev(input int kind, input int row);
    ev_t e;
    if (exp_q.size() == 0) begin
      chk(1'b0, "R5 unexpected event kind", kind, -1);
    end else begin
      e = exp_q.pop_front();
      chk(e.kind == kind, {e.req, " event kind"}, kind, e.kind);
      if (kind == EV_EOM) chk(e.row == row, {e.req, " marker row"}, row, e.row);
    end
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while ((rec_en_o || play_en_o) && n < 500) begin
      step(1);
      n++;
    end
    chk(n < 500, req, n, 500);
  endtask

  // monitor: scoreboard of strobes and LED pulses
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      if (eom_wr_o) got_ev(EV_EOM, int'(row_o));
      if (pwr_dn_o) got_ev(EV_PD, 0);
      if (!led_no && !rec_en_o) begin
        if (led_run == 0) got_ev(EV_LED, 0);
        led_run++;
      end else if (led_run != 0) begin
        chk(led_run == LED_T, "R13 LED pulse length", led_run, LED_T);
        led_run = 0;
      end
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc == 100000 && !done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_ni = 1'b1;
    step(1);
    // R14 reset state
    chk(!rec_en_o && !play_en_o, "R14 enables after reset", {rec_en_o, play_en_o}, 0);
    chk(led_no && !ft_en_o && row_o == 0, "R14 led/ft/row after reset", {led_no, ft_en_o, row_o}, 9'h100);
    chk(!eom_wr_o && !pwr_dn_o, "R14 strobes after reset", {eom_wr_o, pwr_dn_o}, 0);

    // toggle record in slot 1
    start_slot_i = 4'd1; end_slot_i = 4'd1;
    rec_ni = 1'b0;
    step(3);
    chk(rec_en_o && row_o == 8, "R1 record starts at slot row", row_o, 8);
    chk(!led_no, "R1 LED low while recording", led_no, 0);
    rec_ni = 1'b1;
    step(17);
    chk(rec_en_o, "R3 toggle record continues after release", rec_en_o, 1);
    expect_ev(EV_EOM, 8 + 19 / ROW_T, "R3");
    expect_ev(EV_PD, 0, "R3");
    rec_ni = 1'b0;
    step(2);
    rec_ni = 1'b1;
    wait_idle("R3 toggle record ends");
    chk(led_no, "R5 LED off after record", led_no, 1);

    // level-hold record in slots 2..4
    step(3);
    start_slot_i = 4'd2; end_slot_i = 4'd4;
    rec_ni = 1'b0;
    step(45);
    chk(rec_en_o, "R2 level record while held", rec_en_o, 1);
    step(15);
    expect_ev(EV_EOM, 16 + 59 / ROW_T, "R2");
    expect_ev(EV_PD, 0, "R2");
    rec_ni = 1'b1;
    step(2);
    chk(!rec_en_o, "R2 level record stops on release", rec_en_o, 0);

    // toggle record to end of slot 0; inputs changed during it
    step(3);
    start_slot_i = 4'd0; end_slot_i = 4'd0;
    expect_ev(EV_EOM, 7, "R4");
    expect_ev(EV_PD, 0, "R4");
    rec_ni = 1'b0;
    step(2);
    rec_ni = 1'b1;
    step(3);
    start_slot_i = 4'd5; end_slot_i = 4'd6; ft_ni = 1'b0;
    step(5);
    chk(rec_en_o && !ft_en_o, "R11 feed-through ignored in record", ft_en_o, 0);
    ft_ni = 1'b1;
    wait_idle("R4 record ends at end row");

    // toggle play to EOM in row 7
    step(3);
    start_slot_i = 4'd0; end_slot_i = 4'd1;
    expect_ev(EV_PD, 0, "R6");
    expect_ev(EV_LED, 0, "R6");
    play_edge_ni = 1'b0;
    step(2);
    play_edge_ni = 1'b1;
    chk(play_en_o && row_o == 0, "R6 play starts at start row", row_o, 0);
    wait_idle("R6 play ends at marker");
    step(8);

    // toggle play to end row without marker; hold-play pulse ignored
    start_slot_i = 4'd5; end_slot_i = 4'd5;
    expect_ev(EV_PD, 0, "R6");
    play_edge_ni = 1'b0;
    step(2);
    play_edge_ni = 1'b1;
    step(5);
    play_lvl_ni = 1'b0;
    step(2);
    play_lvl_ni = 1'b1;
    chk(play_en_o && row_o == 42, "R11 hold-play ignored in toggle play", row_o, 42);
    wait_idle("R6 play ends at end row");
    step(8);

    // retrigger stops toggle play
    start_slot_i = 4'd5; end_slot_i = 4'd6;
    play_edge_ni = 1'b0;
    step(2);
    play_edge_ni = 1'b1;
    step(10);
    expect_ev(EV_PD, 0, "R7");
    play_edge_ni = 1'b0;
    step(2);
    play_edge_ni = 1'b1;
    step(3);
    chk(!play_en_o, "R7 retrigger stops play", play_en_o, 0);

    // hold play loops over slot 0 with feed-through on
    ft_ni = 1'b0;
    step(2);
    chk(ft_en_o, "R10 feed-through follows input in idle", ft_en_o, 1);
    start_slot_i = 4'd0; end_slot_i = 4'd0;
    expect_ev(EV_LED, 0, "R8");
    expect_ev(EV_LED, 0, "R8");
    play_lvl_ni = 1'b0;
    step(30);
    chk(play_en_o && !ft_en_o, "R10 feed-through off in play", ft_en_o, 0);
    step(30);
    expect_ev(EV_PD, 0, "R8");
    play_lvl_ni = 1'b1;
    step(3);
    chk(!play_en_o, "R8 hold play stops on release", play_en_o, 0);
    chk(ft_en_o, "R10 feed-through restored after play", ft_en_o, 1);

    // play overrides a recording in slot 3
    step(6);
    start_slot_i = 4'd3; end_slot_i = 4'd3;
    rec_ni = 1'b0;
    step(2);
    rec_ni = 1'b1;
    step(8);
    chk(rec_en_o && ft_en_o, "R10 feed-through kept in record", ft_en_o, 1);
    expect_ev(EV_EOM, 24 + 9 / ROW_T, "R9");
    expect_ev(EV_PD, 0, "R9");
    expect_ev(EV_LED, 0, "R9");
    play_edge_ni = 1'b0;
    step(1);
    chk(play_en_o && !rec_en_o && row_o == 24, "R9 play follows override", row_o, 24);
    step(1);
    play_edge_ni = 1'b1;
    wait_idle("R9 override play ends");
    step(8);

    // play trigger in the cycle recording reaches the end row
    ft_ni = 1'b1;
    start_slot_i = 4'd6; end_slot_i = 4'd6;
    rec_ni = 1'b0;
    step(2);
    rec_ni = 1'b1;
    step(22);
    expect_ev(EV_EOM, 55, "R9 coincident");
    expect_ev(EV_PD, 0, "R9 coincident");
    expect_ev(EV_LED, 0, "R9 coincident");
    play_edge_ni = 1'b0;
    step(2);
    play_edge_ni = 1'b1;
    chk(play_en_o, "R9 coincident play wins", play_en_o, 1);
    wait_idle("R9 coincident play ends");
    step(8);

    // rejected span
    start_slot_i = 4'd9; end_slot_i = 4'd3;
    rec_ni = 1'b0;
    step(5);
    chk(!rec_en_o, "R12 reversed span rejected for record", rec_en_o, 0);
    rec_ni = 1'b1;
    play_edge_ni = 1'b0;
    step(3);
    chk(!play_en_o, "R12 reversed span rejected for play", play_en_o, 0);
    play_edge_ni = 1'b1;
    step(5);

    chk(exp_q.size() == 0, "R5 all expected events seen", exp_q.size(), 0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule